// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog peripheral for a small microcontroller. It owns an 8-bit control/status register that the CPU bus writes and reads, a restart input pulsed by the watchdog-restart instruction, and a tick input: a one-cycle enable pulse that comes from a slow watchdog oscillator domain (about 128 kHz). The counter moves only on those ticks. When it reaches the timeout chosen by a 4-bit scale field, the block asks either for an interrupt or for a system reset.

Software cannot change the enable bit or the timeout field with a plain write. It must first write a value with both the unlock bit and the enable bit set. This opens a short window, and one more write made inside it is accepted. An expiry in interrupt mode clears the interrupt-enable bit in hardware, so if software does not react, the next expiry resets the system. A sticky cause flag records that the watchdog caused a reset. Software clears it by writing zero to it.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00 (scale 0, watchdog disabled, interrupt disabled, window closed), and `sys_rst_req`, `wdt_irq` and `wdt_cause` are all low.
- R2: A register write with bit 4 (unlock) and bit 3 (enable) both 1 opens a change window, and bit 4 reads back as 1 while the window is open. A write on any of the 4 clock cycles after the opening write is accepted and closes the window. A write 5 cycles after the opening write is treated as an unprotected write.
- R3: Outside an open window, a write leaves bit 3 (enable) and the scale bits {bit5, bit2, bit1, bit0} unchanged. Bit 6 (interrupt enable) takes the written value on any write.
- R4: The timeout is BASE_TICKS << s ticks, where s = {bit5, bit2, bit1, bit0} and values above 9 act as 9. In reset mode (bit 3 = 1, bit 6 = 0), `sys_rst_req` pulses for one cycle, one clock after the tick that completes the timeout.
- R5: A reset-mode expiry sets `wdt_cause`, which maps to bit 3 of the system reset-status register. The flag stays set until a `cause_we` strobe with `cause_wdata` = 0. Writing 1 has no effect.
- R6: When bit 6 is set, an expiry pulses `wdt_irq` for one cycle and clears bit 6. With bit 3 still set, the next expiry requests a reset.
- R7: A `kick` pulse restarts the count, so the next expiry comes one full timeout after the last kick.
- R8: Using the window to write 0 disables the watchdog. No reset or interrupt follows, however long it stays idle.
- R9: The count advances only on cycles where `tick` is high, so with ticks every 8 clocks the timeout stretches eightfold.
- R10: Every accepted window write restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low power-on reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register read value |
| kick | input | 1 | Watchdog restart strobe |
| tick | input | 1 | One-cycle pulse from the slow watchdog clock |
| cause_we | input | 1 | Write strobe for the reset-cause flag |
| cause_wdata | input | 1 | Value written to the cause flag (0 clears) |
| sys_rst_req | output | 1 | One-cycle system reset request |
| wdt_irq | output | 1 | One-cycle watchdog interrupt request |
| wdt_cause | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The timeout is measured in cycles for several register settings: scales 0, 1 and 2 in reset mode, and scale 0 in interrupt mode. These show that the scale shifts the limit, and that interrupt mode behaves differently, with bit 6 cleared and a second period ending in a reset. Unlock writes placed 4 and 5 cycles after the opening write show exactly where the window ends. A plain write of the enable and scale bits shows that an unprotected write is ignored. A kick in mid-count, a protected disable and a sparse tick pattern show, in turn, the restart point, the quiet state and the gating of the counter by ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control register bit positions (software-visible encoding)
    localparam int BIT_S0 = 0;
    localparam int BIT_S1 = 1;
    localparam int BIT_S2 = 2;
    localparam int BIT_EN = 3;
    localparam int BIT_UL = 4;
    localparam int BIT_S3 = 5;
    localparam int BIT_IE = 6;

    // Largest effective scale exponent
    localparam int MAX_SHIFT = 9;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic [3:0] scale;
    } cfg_t;

    function automatic logic [3:0] scale_of(input logic [7:0] v);
        return {v[BIT_S3], v[BIT_S2], v[BIT_S1], v[BIT_S0]};
    endfunction

    function automatic logic [3:0] clamp_shift(input logic [3:0] s);
        return (s > 4'(MAX_SHIFT)) ? 4'(MAX_SHIFT) : s;
    endfunction

    function automatic logic [7:0] pack_csr(input cfg_t c, input logic win);
        logic [7:0] v;
        v          = 8'h00;
        v[BIT_S0]  = c.scale[0];
        v[BIT_S1]  = c.scale[1];
        v[BIT_S2]  = c.scale[2];
        v[BIT_S3]  = c.scale[3];
        v[BIT_EN]  = c.en;
        v[BIT_UL]  = win;
        v[BIT_IE]  = c.ie;
        return v;
    endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [6:0] wdata,
    input  logic       clr_ie,
    output cfg_t       cfg,
    output logic       win_open,
    output logic       reload
);

    localparam int WW = $clog2(WINDOW + 1);

    typedef struct packed {
        cfg_t          cfg;
        logic [WW-1:0] win;
    } st_t;

    st_t  st_d, st_q;
    logic accept;
    logic opener;

    always_comb begin
        st_d   = st_q;
        accept = we && (st_q.win != '0);
        opener = wdata[BIT_UL] && wdata[BIT_EN];
        if (st_q.win != '0) begin
            st_d.win = st_q.win - WW'(1);
        end
        if (clr_ie) begin
            st_d.cfg.ie = 1'b0;
        end
        if (we) begin
            st_d.cfg.ie = wdata[BIT_IE];
            if (accept) begin
                st_d.cfg.en    = wdata[BIT_EN];
                st_d.cfg.scale = scale_of({1'b0, wdata});
                st_d.win       = '0;
            end else if (opener) begin
                st_d.win = WW'(WINDOW);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign win_open = (st_q.win != '0);
    assign reload   = accept;

    // R3
    scale_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !win_open) |=> ($stable(st_q.cfg.scale) && $stable(st_q.cfg.en)));

    // R2
    win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(we && wdata[BIT_UL] && wdata[BIT_EN]));

    // R6
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ie && !we) |=> !st_q.cfg.ie);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tick,
    input  logic       restart,
    input  logic [3:0] scale,
    output logic       expire
);

    localparam int CW = $clog2(BASE_TICKS) + MAX_SHIFT + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] last;

    always_comb begin
        limit  = CW'(BASE_TICKS) << clamp_shift(scale);
        last   = limit - CW'(1);
        expire = active && tick && !restart && (st_q.cnt == last);
        st_d   = st_q;
        if (!active || restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = expire ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !restart) |=> $stable(st_q.cnt));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdog_event.sv
module wdog_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ie,
    input  logic en,
    input  logic cause_we,
    input  logic cause_wdata,
    output logic clr_ie,
    output logic rst_req,
    output logic irq,
    output logic cause
);

    typedef struct packed {
        logic rst;
        logic irq;
        logic cause;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        clr_ie   = expire && ie;
        st_d.irq = expire && ie;
        st_d.rst = expire && !ie && en;
        if (st_d.rst) begin
            st_d.cause = 1'b1;
        end else if (cause_we && !cause_wdata) begin
            st_d.cause = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.rst;
    assign irq     = st_q.irq;
    assign cause   = st_q.cause;

    // R5
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> st_q.cause);

    // R5
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cause && !(cause_we && !cause_wdata)) |=> st_q.cause);

    // R6
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.irq && st_q.rst));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 2048,
    parameter int WINDOW     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_we,
    input  logic [7:0] csr_wdata,
    output logic [7:0] csr_rdata,
    input  logic       kick,
    input  logic       tick,
    input  logic       cause_we,
    input  logic       cause_wdata,
    output logic       sys_rst_req,
    output logic       wdt_irq,
    output logic       wdt_cause
);

    cfg_t cfg;
    logic win_open;
    logic reload;
    logic expire;
    logic clr_ie;
    logic active;
    logic unused_hi;

    assign unused_hi = csr_wdata[7];
    assign active    = cfg.en || cfg.ie;

    wdog_cfg #(.WINDOW(WINDOW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (csr_we),
        .wdata    (csr_wdata[6:0]),
        .clr_ie   (clr_ie),
        .cfg      (cfg),
        .win_open (win_open),
        .reload   (reload)
    );

    wdog_count #(.BASE_TICKS(BASE_TICKS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .tick    (tick),
        .restart (kick || reload),
        .scale   (cfg.scale),
        .expire  (expire)
    );

    wdog_event u_event (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .ie          (cfg.ie),
        .en          (cfg.en),
        .cause_we    (cause_we),
        .cause_wdata (cause_wdata),
        .clr_ie      (clr_ie),
        .rst_req     (sys_rst_req),
        .irq         (wdt_irq),
        .cause       (wdt_cause)
    );

    assign csr_rdata = pack_csr(cfg, win_open);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sys_rst_req && !wdt_irq));

endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] csr_rdata;
    logic       kick = 1'b0;
    logic       tick = 1'b1;
    logic       cause_we = 1'b0;
    logic       cause_wdata = 1'b0;
    logic       sys_rst_req;
    logic       wdt_irq;
    logic       wdt_cause;

    logic       slow = 1'b0;
    logic [2:0] div = 3'd0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        div  <= div + 3'd1;
        tick <= slow ? (div == 3'd7) : 1'b1;
    end

    wdog_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_we      (csr_we),
        .csr_wdata   (csr_wdata),
        .csr_rdata   (csr_rdata),
        .kick        (kick),
        .tick        (tick),
        .cause_we    (cause_we),
        .cause_wdata (cause_wdata),
        .sys_rst_req (sys_rst_req),
        .wdt_irq     (wdt_irq),
        .wdt_cause   (wdt_cause)
    );

    // Stimulus table: register value, expected cycles to event, interrupt mode
    localparam int NV = 4;
    localparam logic [7:0] T_CFG [NV] = '{8'h08, 8'h09, 8'h48, 8'h0A};
    localparam int         T_CYC [NV] = '{2048, 4096, 2048, 8192};
    localparam bit         T_IRQ [NV] = '{1'b0, 1'b0, 1'b1, 1'b0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic csr_write(input logic [7:0] v);
        csr_we    = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input bit want_irq, input int lim, output int k);
        k = 0;
        while (k < lim && !(want_irq ? wdt_irq : sys_rst_req)) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k;
        int hits;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check(csr_rdata == 8'h00, "R1 rdata", csr_rdata, 0);
        check({sys_rst_req, wdt_irq, wdt_cause} == 3'b000, "R1 outputs",
              {sys_rst_req, wdt_irq, wdt_cause}, 0);

        // R3 unprotected write of enable and scale is ignored; bit 6 is free
        csr_write(8'h2F);
        check(csr_rdata == 8'h00, "R3 plain write", csr_rdata, 8'h00);
        csr_write(8'h40);
        check(csr_rdata == 8'h40, "R3 ie write", csr_rdata, 8'h40);
        csr_write(8'h00);

        // R2 window: write 4 cycles after the opener is accepted
        csr_write(8'h18);
        check(csr_rdata[4] == 1'b1, "R2 window flag", csr_rdata[4], 1);
        idle(3);
        csr_write(8'h07);
        check(csr_rdata == 8'h07, "R2 accept at 4", csr_rdata, 8'h07);
        // R2 write 5 cycles after the opener is rejected
        csr_write(8'h18);
        idle(4);
        csr_write(8'h01);
        check(csr_rdata == 8'h07, "R2 reject at 5", csr_rdata, 8'h07);

        // Table walk: R4 timeout per scale, R10 restart on window write, R6 irq mode
        for (int i = 0; i < NV; i++) begin
            csr_write(8'h18);
            csr_write(T_CFG[i]);
            measure(T_IRQ[i], T_CYC[i] + 16, k);
            check(k == T_CYC[i], T_IRQ[i] ? "R6 irq timeout" : "R4 R10 reset timeout",
                  k, T_CYC[i]);
            if (T_IRQ[i]) begin
                check(csr_rdata[6] == 1'b0, "R6 ie cleared", csr_rdata[6], 0);
                @(negedge clk);
                measure(1'b0, 2048 + 16, k);
                check(k == 2047, "R6 second expiry resets", k, 2047);
            end
            check(wdt_cause == 1'b1, "R5 cause set", wdt_cause, 1);
        end

        // R5 writing 1 keeps the flag, writing 0 clears it
        cause_we = 1'b1; cause_wdata = 1'b1;
        @(negedge clk);
        cause_we = 1'b0;
        check(wdt_cause == 1'b1, "R5 write one", wdt_cause, 1);
        cause_we = 1'b1; cause_wdata = 1'b0;
        @(negedge clk);
        cause_we = 1'b0;
        check(wdt_cause == 1'b0, "R5 write zero", wdt_cause, 0);

        // R7 kick mid-count restarts the timeout
        csr_write(8'h18);
        csr_write(8'h08);
        idle(1500);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        measure(1'b0, 2048 + 16, k);
        check(k == 2048, "R7 kick restart", k, 2048);

        // R8 protected disable: no event afterwards
        idle(1000);
        csr_write(8'h18);
        csr_write(8'h00);
        hits = 0;
        for (int c = 0; c < 6000; c++) begin
            if (sys_rst_req || wdt_irq) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R8 quiet after disable", hits, 0);
        check(csr_rdata == 8'h00, "R8 rdata", csr_rdata, 0);

        // R9 sparse ticks: one per 8 clocks stretches the timeout
        slow = 1'b1;
        csr_write(8'h18);
        csr_write(8'h08);
        measure(1'b0, 2048 * 8 + 64, k);
        check(k > 2048 * 8 - 8 && k <= 2048 * 8, "R9 tick gating", k, 2048 * 8);
        slow = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule